// File: doc/BRIEF.md
# Satellite Switch Control-Message Slave

This block is the command side of a satellite IF switch slave that listens on a two-way control bus. An upstream deframer has already taken care of tone demodulation, bit timing and parity. It delivers each master message as a byte stream: a framing byte, an address byte, a command byte and, for some commands, one data byte. The last byte of each message is marked with an end strobe. The block checks the framing byte and the address against its own role and register contents. It then runs the command against its internal state: device address, status flags, a fixed capability byte, the four-bit switch selection and the low and high local-oscillator frequency tables.

When the framing byte asks for an answer, the block emits a reply over a valid/ready byte port. The reply is a fixed reply header followed by any data bytes. The four switch-selection bits are also driven in parallel, so that an RF multiplexer can follow them directly. A role input chooses between the LNB role and the multiswitch role. The role sets which device address is honoured and the address the block takes after reset.

Top module: `diseqc_slave_ctrl`

## Requirements
- R1: A message is acted on only when its framing byte lies in 0xE0..0xE7. Any other framing byte leaves all state unchanged and produces no reply.
- R2: A reply is produced only when the framing byte is 0xE2 or 0xE3 and the command takes effect. Every reply starts with byte 0xE4, followed by the command's data bytes in order. Each byte is held stable until accepted with out_ready.
- R3: Address bytes 0x00 and 0x10 always match, as does the current address register. The address register resets to 0x11 when lnb_role=1 and to 0x14 when lnb_role=0. Any other address is ignored.
- R4: Commands 0x20..0x23 clear switch bits 4, 5, 6 and 7. Commands 0x24..0x27 set the same bits. sw_state[3:0] carries bits 7..4: option, satellite, polarization (1=horizontal) and band (1=high).
- R5: Command 0x14 returns the switch byte {option, satellite, polarization, band, cascade_avail, 1, 1, 1}.
- R6: Command 0x10 returns status {contention, 0, 0, 0, 0, dc_high, sleep, reset-flag}. After reset the reset flag is 1 and the other flags are 0. Command 0x01 clears the reset flag. Command 0x04 sets contention and 0x06 clears it. Command 0x00 restores the status flags, the switch bits and the address to their reset values.
- R7: Commands 0x05 (read address) and 0x08 (write address from the data byte) take effect only while contention is set. Commands 0x07 and 0x09 take effect only while contention is clear. When gated off, such a command changes nothing and sends no reply.
- R8: Command 0x30 enters sleep and command 0x31 leaves it. While asleep, every other command has no effect and gets no reply.
- R9: Command 0x11 returns the capability byte 0x03.
- R10: The LOF tables hold BCD digits: 09750 MHz with entry 2 for low band, 10600 MHz with entry 4 for high band. Command 0x50 returns two bytes from the table the band bit selects: {10 GHz digit, 1 GHz digit}, then {100 MHz digit, 10 MHz digit}. Command 0x51 returns that table's entry number. Commands 0x52 and 0x53 return the low and high entry numbers.
- R11: Command 0x38 takes one data byte. Data bits 3..0 set switch bits 4..7 and data bits 7..4 clear switch bits 4..7. A set wins over a clear at the same position.
- R12: A message whose length differs from its command's length, or whose command is not supported, leaves all state unchanged and sends no reply. Message lengths are 4 bytes for 0x08, 0x09 and 0x38, and 3 bytes for every other supported command.
- R13: Under reset, sw_state is 0 and out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lnb_role | input | 1 | 1 = LNB role, 0 = multiswitch role; static while out of reset |
| cascade_avail | input | 1 | A cascade input is present; reported in the switch byte |
| dc_high | input | 1 | Supply voltage level seen by the receiver; reported in status |
| in_valid | input | 1 | Message byte present |
| in_byte | input | 8 | Message byte |
| in_last | input | 1 | Marks the final byte of a message |
| out_ready | input | 1 | Reply sink accepts the current byte |
| out_valid | output | 1 | Reply byte present |
| out_byte | output | 8 | Reply byte |
| sw_state | output | 4 | Switch selection {option, satellite, polarization, band} |

## Verification
The assertions assume that no message byte arrives while a reply is still being delivered. They also assume that lnb_role, cascade_avail and dc_high stay constant between the last byte of a message and the point where it takes effect. The stimulus keeps to this by sending one message at a time and waiting until every expected reply byte has been taken, plus a few idle cycles. The strap inputs change only while reset is held. The sink throttles out_ready in a repeating pattern, so that reply bytes must be held across stalls.

// File: rtl/diseqc_pkg.sv
package diseqc_pkg;

  typedef logic [7:0] byte_t;

  localparam byte_t REPLY_HEAD       = 8'hE4;
  localparam byte_t CMD_RESET        = 8'h00;
  localparam byte_t CMD_CLR_RESET    = 8'h01;
  localparam byte_t CMD_SET_CONT     = 8'h04;
  localparam byte_t CMD_ADDR_IF_CONT = 8'h05;
  localparam byte_t CMD_CLR_CONT     = 8'h06;
  localparam byte_t CMD_ADDR_NO_CONT = 8'h07;
  localparam byte_t CMD_MOVE_IF_CONT = 8'h08;
  localparam byte_t CMD_MOVE_NO_CONT = 8'h09;
  localparam byte_t CMD_RD_STATUS    = 8'h10;
  localparam byte_t CMD_RD_CONFIG    = 8'h11;
  localparam byte_t CMD_RD_SWITCH    = 8'h14;
  localparam byte_t CMD_SLEEP        = 8'h30;
  localparam byte_t CMD_AWAKE        = 8'h31;
  localparam byte_t CMD_PORT_GROUP   = 8'h38;
  localparam byte_t CMD_LOF_STRING   = 8'h50;
  localparam byte_t CMD_LOF_NOW      = 8'h51;
  localparam byte_t CMD_LOF_LOW      = 8'h52;
  localparam byte_t CMD_LOF_HIGH     = 8'h53;
  localparam byte_t CAPABILITY       = 8'h03;
  localparam byte_t ADDR_ANY         = 8'h00;
  localparam byte_t ADDR_FAMILY      = 8'h10;
  localparam byte_t ADDR_LNB         = 8'h11;
  localparam byte_t ADDR_SWITCHER    = 8'h14;

  // Expected message length of a command; 0 marks an unsupported command.
  function automatic logic [2:0] cmd_len(input byte_t c);
    case (c)
      CMD_MOVE_IF_CONT, CMD_MOVE_NO_CONT, CMD_PORT_GROUP: cmd_len = 3'd4;
      CMD_RESET, CMD_CLR_RESET, CMD_SET_CONT, CMD_ADDR_IF_CONT, CMD_CLR_CONT,
      CMD_ADDR_NO_CONT, CMD_RD_STATUS, CMD_RD_CONFIG, CMD_RD_SWITCH,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27,
      CMD_SLEEP, CMD_AWAKE,
      CMD_LOF_STRING, CMD_LOF_NOW, CMD_LOF_LOW, CMD_LOF_HIGH: cmd_len = 3'd3;
      default: cmd_len = 3'd0;
    endcase
  endfunction

  // Port-group write: low nibble sets, high nibble clears, set wins.
  function automatic logic [3:0] nib_update(input logic [3:0] cur, input byte_t d);
    nib_update = (cur & ~d[7:4]) | d[3:0];
  endfunction

  // Decimal digit at position pos (0 = units) of val.
  function automatic logic [3:0] bcd_digit(input int unsigned val, input int unsigned pos);
    int unsigned v;
    v = val;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < pos) v = v / 10;
    end
    bcd_digit = 4'(v % 10);
  endfunction

  // Table byte idx (2, 1 or 0) of a frequency given in MHz plus its entry number.
  function automatic byte_t lof_reg(input int unsigned mhz, input int unsigned entry,
                                    input int unsigned idx);
    case (idx)
      2:       lof_reg = {bcd_digit(mhz, 4), bcd_digit(mhz, 3)};
      1:       lof_reg = {bcd_digit(mhz, 2), bcd_digit(mhz, 1)};
      default: lof_reg = {bcd_digit(mhz, 0), 4'(entry)};
    endcase
  endfunction

endpackage

// File: rtl/dsq_msg_collect.sv
module dsq_msg_collect #(
  parameter int MSG_MAX = 4,
  localparam int LW = $clog2(MSG_MAX + 2)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic [7:0]                   in_byte,
  input  logic                         in_last,
  output logic                         msg_done,
  output logic [LW-1:0]                msg_len,
  output logic [MSG_MAX-1:0][7:0]      msg_bytes
);

  localparam logic [LW-1:0] CNT_SAT = LW'(MSG_MAX + 1);

  logic [LW-1:0] cnt_q;
  logic [LW-1:0] cnt_nxt;

  assign cnt_nxt = (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      msg_done <= 1'b0;
      msg_len  <= '0;
    end else begin
      msg_done <= 1'b0;
      if (in_valid) begin
        if (in_last) begin
          cnt_q    <= '0;
          msg_len  <= cnt_nxt;
          msg_done <= 1'b1;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  for (genvar k = 0; k < MSG_MAX; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             msg_bytes[k] <= '0;
      else if (in_valid && cnt_q == LW'(k))   msg_bytes[k] <= in_byte;
    end
  end

endmodule

// File: rtl/dsq_exec.sv
module dsq_exec
  import diseqc_pkg::*;
#(
  parameter int MSG_MAX    = 4,
  parameter int REPLY_MAX  = 3,
  parameter int LOW_MHZ    = 9750,
  parameter int LOW_ENTRY  = 2,
  parameter int HIGH_MHZ   = 10600,
  parameter int HIGH_ENTRY = 4,
  localparam int LW = $clog2(MSG_MAX + 2),
  localparam int RW = $clog2(REPLY_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        lnb_role,
  input  logic                        cascade_avail,
  input  logic                        dc_high,
  input  logic                        msg_done,
  input  logic [LW-1:0]               msg_len,
  input  logic [MSG_MAX-1:0][7:0]     msg_bytes,
  output logic [3:0]                  sw_state,
  output logic                        asleep,
  output logic                        rep_load,
  output logic [RW-1:0]               rep_len,
  output logic [REPLY_MAX-1:0][7:0]   rep_data
);

  localparam byte_t LO2 = lof_reg(LOW_MHZ, LOW_ENTRY, 2);
  localparam byte_t LO1 = lof_reg(LOW_MHZ, LOW_ENTRY, 1);
  localparam byte_t LO0 = lof_reg(LOW_MHZ, LOW_ENTRY, 0);
  localparam byte_t HI2 = lof_reg(HIGH_MHZ, HIGH_ENTRY, 2);
  localparam byte_t HI1 = lof_reg(HIGH_MHZ, HIGH_ENTRY, 1);
  localparam byte_t HI0 = lof_reg(HIGH_MHZ, HIGH_ENTRY, 0);

  byte_t       addr_q, addr_n, addr_dflt;
  logic        cont_q, cont_n, slp_q, slp_n, rstf_q, rstf_n;
  logic [3:0]  sw_q, sw_n;

  byte_t       fr, ad, cm, dt;
  logic        frame_ok, rep_req, addr_hit, len_ok, accept, gate_ok, run;
  logic [2:0]  need_len;
  byte_t       status_byte, switch_byte;

  assign fr = msg_bytes[0];
  assign ad = msg_bytes[1];
  assign cm = msg_bytes[2];
  assign dt = msg_bytes[3];

  assign addr_dflt   = lnb_role ? ADDR_LNB : ADDR_SWITCHER;
  assign frame_ok    = (fr[7:3] == 5'b11100);
  assign rep_req     = frame_ok && (fr[2:1] == 2'b01);
  assign addr_hit    = (ad == ADDR_ANY) || (ad == ADDR_FAMILY) || (ad == addr_q);
  assign need_len    = cmd_len(cm);
  assign len_ok      = (need_len != 3'd0) && (msg_len == LW'(need_len));
  assign accept      = msg_done && frame_ok && addr_hit && len_ok &&
                       (!slp_q || cm == CMD_AWAKE);
  assign run         = accept && gate_ok;
  assign status_byte = {cont_q, 4'b0000, dc_high, slp_q, rstf_q};
  assign switch_byte = {sw_q, cascade_avail, 3'b111};

  always_comb begin
    addr_n   = addr_q;
    cont_n   = cont_q;
    slp_n    = slp_q;
    rstf_n   = rstf_q;
    sw_n     = sw_q;
    gate_ok  = 1'b1;
    rep_len  = RW'(1);
    rep_data = '0;
    rep_data[0] = REPLY_HEAD;
    case (cm)
      CMD_RESET: begin
        addr_n = addr_dflt;
        cont_n = 1'b0;
        slp_n  = 1'b0;
        rstf_n = 1'b1;
        sw_n   = 4'h0;
      end
      CMD_CLR_RESET: rstf_n = 1'b0;
      CMD_SET_CONT:  cont_n = 1'b1;
      CMD_CLR_CONT:  cont_n = 1'b0;
      CMD_ADDR_IF_CONT: begin
        gate_ok     = cont_q;
        rep_len     = RW'(2);
        rep_data[1] = addr_q;
      end
      CMD_ADDR_NO_CONT: begin
        gate_ok     = !cont_q;
        rep_len     = RW'(2);
        rep_data[1] = addr_q;
      end
      CMD_MOVE_IF_CONT: begin
        gate_ok = cont_q;
        addr_n  = dt;
      end
      CMD_MOVE_NO_CONT: begin
        gate_ok = !cont_q;
        addr_n  = dt;
      end
      CMD_RD_STATUS: begin
        rep_len     = RW'(2);
        rep_data[1] = status_byte;
      end
      CMD_RD_CONFIG: begin
        rep_len     = RW'(2);
        rep_data[1] = CAPABILITY;
      end
      CMD_RD_SWITCH: begin
        rep_len     = RW'(2);
        rep_data[1] = switch_byte;
      end
      8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27:
        sw_n[cm[1:0]] = cm[2];
      CMD_SLEEP:      slp_n = 1'b1;
      CMD_AWAKE:      slp_n = 1'b0;
      CMD_PORT_GROUP: sw_n  = nib_update(sw_q, dt);
      CMD_LOF_STRING: begin
        rep_len     = RW'(3);
        rep_data[1] = sw_q[0] ? HI2 : LO2;
        rep_data[2] = sw_q[0] ? HI1 : LO1;
      end
      CMD_LOF_NOW: begin
        rep_len     = RW'(2);
        rep_data[1] = {4'h0, sw_q[0] ? HI0[3:0] : LO0[3:0]};
      end
      CMD_LOF_LOW: begin
        rep_len     = RW'(2);
        rep_data[1] = {4'h0, LO0[3:0]};
      end
      CMD_LOF_HIGH: begin
        rep_len     = RW'(2);
        rep_data[1] = {4'h0, HI0[3:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= addr_dflt;
      cont_q <= 1'b0;
      slp_q  <= 1'b0;
      rstf_q <= 1'b1;
      sw_q   <= 4'h0;
    end else if (run) begin
      addr_q <= addr_n;
      cont_q <= cont_n;
      slp_q  <= slp_n;
      rstf_q <= rstf_n;
      sw_q   <= sw_n;
    end
  end

  assign rep_load = run && rep_req;
  assign sw_state = sw_q;
  assign asleep   = slp_q;

endmodule

// File: rtl/dsq_reply_tx.sv
module dsq_reply_tx #(
  parameter int REPLY_MAX = 3,
  localparam int RW = $clog2(REPLY_MAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rep_load,
  input  logic [RW-1:0]               rep_len,
  input  logic [REPLY_MAX-1:0][7:0]   rep_data,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [7:0]                  out_byte
);

  logic [REPLY_MAX-1:0][7:0] buf_q;
  logic [RW-1:0]             len_q;
  logic [RW-1:0]             idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q     <= '0;
      len_q     <= '0;
      idx_q     <= '0;
      out_valid <= 1'b0;
    end else if (rep_load) begin
      buf_q     <= rep_data;
      len_q     <= rep_len;
      idx_q     <= '0;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (idx_q == len_q - 1'b1) out_valid <= 1'b0;
      else                       idx_q     <= idx_q + 1'b1;
    end
  end

  assign out_byte = buf_q[idx_q];

endmodule

// File: rtl/diseqc_slave_ctrl.sv
module diseqc_slave_ctrl #(
  parameter int MSG_MAX    = 4,
  parameter int REPLY_MAX  = 3,
  parameter int LOW_MHZ    = 9750,
  parameter int LOW_ENTRY  = 2,
  parameter int HIGH_MHZ   = 10600,
  parameter int HIGH_ENTRY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lnb_role,
  input  logic       cascade_avail,
  input  logic       dc_high,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic       in_last,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_byte,
  output logic [3:0] sw_state
);

  localparam int LW = $clog2(MSG_MAX + 2);
  localparam int RW = $clog2(REPLY_MAX + 1);

  logic                       msg_done;
  logic [LW-1:0]              msg_len;
  logic [MSG_MAX-1:0][7:0]    msg_bytes;
  logic [7:0]                 msg_cmd;
  logic                       asleep;
  logic                       rep_load;
  logic [RW-1:0]              rep_len;
  logic [REPLY_MAX-1:0][7:0]  rep_data;

  assign msg_cmd = msg_bytes[2];

  dsq_msg_collect #(.MSG_MAX(MSG_MAX)) collect_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_last(in_last), .msg_done(msg_done), .msg_len(msg_len),
    .msg_bytes(msg_bytes)
  );

  dsq_exec #(
    .MSG_MAX(MSG_MAX), .REPLY_MAX(REPLY_MAX), .LOW_MHZ(LOW_MHZ),
    .LOW_ENTRY(LOW_ENTRY), .HIGH_MHZ(HIGH_MHZ), .HIGH_ENTRY(HIGH_ENTRY)
  ) exec_i (
    .clk(clk), .rst_n(rst_n), .lnb_role(lnb_role), .cascade_avail(cascade_avail),
    .dc_high(dc_high), .msg_done(msg_done), .msg_len(msg_len),
    .msg_bytes(msg_bytes), .sw_state(sw_state), .asleep(asleep),
    .rep_load(rep_load), .rep_len(rep_len), .rep_data(rep_data)
  );

  dsq_reply_tx #(.REPLY_MAX(REPLY_MAX)) reply_i (
    .clk(clk), .rst_n(rst_n), .rep_load(rep_load), .rep_len(rep_len),
    .rep_data(rep_data), .out_ready(out_ready), .out_valid(out_valid),
    .out_byte(out_byte)
  );

endmodule

// File: rtl/diseqc_slave_ctrl_chk.sv
module diseqc_slave_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_byte,
  input logic [3:0] sw_state,
  input logic       msg_done,
  input logic [7:0] msg_cmd,
  input logic       asleep
);

  assert_reply_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_byte == 8'hE4);

  assert_reply_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !out_valid);

  assert_switch_only_on_msg_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_done |=> $stable(sw_state));

  assert_sleep_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && msg_done && msg_cmd != 8'h31) |=> ($stable(sw_state) && !$rose(out_valid)));

  assert_reset_idle_R13: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && sw_state == 4'h0));

endmodule

bind diseqc_slave_ctrl diseqc_slave_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_ready(out_ready), .out_byte(out_byte), .sw_state(sw_state),
  .msg_done(msg_done), .msg_cmd(msg_cmd), .asleep(asleep)
);

// File: tb/diseqc_slave_ctrl_tb.sv
module diseqc_slave_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lnb_role = 1'b1;
  logic       cascade_avail = 1'b1;
  logic       dc_high = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_last = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_byte;
  logic [3:0] sw_state;

  always #5 clk = ~clk;

  diseqc_slave_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .lnb_role(lnb_role), .cascade_avail(cascade_avail),
    .dc_high(dc_high), .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
    .sw_state(sw_state)
  );

  int    checks = 0;
  int    fails = 0;
  bit    finished = 0;
  string cur_req = "R13";

  // Behavioural reference state
  int m_addr = 8'h11, m_cont = 0, m_slp = 0, m_rst = 1;
  int m_opt = 0, m_sat = 0, m_pol = 0, m_band = 0;
  logic [7:0] exp_q[$];
  logic [7:0] msg[$];
  int rdy_cnt = 0;

  function automatic logic [3:0] model_sw();
    return {m_opt[0], m_sat[0], m_pol[0], m_band[0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_addr = lnb_role ? 8'h11 : 8'h14;
    m_cont = 0; m_slp = 0; m_rst = 1;
    m_opt = 0; m_sat = 0; m_pol = 0; m_band = 0;
  endtask

  task automatic model_apply();
    int n, need, fr, ad, cm, d;
    bit ok, rep;
    logic [7:0] r[$];
    int bits[4];
    n = msg.size();
    if (n < 3) return;
    fr = msg[0]; ad = msg[1]; cm = msg[2];
    d = (n > 3) ? int'(msg[3]) : 0;
    if (fr < 'hE0 || fr > 'hE7) return;
    if (!(ad == 0 || ad == 'h10 || ad == m_addr)) return;
    need = 0;
    if (cm == 'h08 || cm == 'h09 || cm == 'h38) need = 4;
    else if (cm inside {'h00, 'h01, 'h04, 'h05, 'h06, 'h07, 'h10, 'h11, 'h14,
                        ['h20:'h27], 'h30, 'h31, ['h50:'h53]}) need = 3;
    if (need == 0 || n != need) return;
    if (m_slp != 0 && cm != 'h31) return;
    rep = (fr == 'hE2 || fr == 'hE3);
    ok = 1;
    case (cm)
      'h00: model_reset();
      'h01: m_rst = 0;
      'h04: m_cont = 1;
      'h06: m_cont = 0;
      'h05: if (m_cont == 0) ok = 0; else r.push_back(8'(m_addr));
      'h07: if (m_cont != 0) ok = 0; else r.push_back(8'(m_addr));
      'h08: if (m_cont == 0) ok = 0; else m_addr = d;
      'h09: if (m_cont != 0) ok = 0; else m_addr = d;
      'h10: r.push_back(8'(m_cont * 128 + int'(dc_high) * 4 + m_slp * 2 + m_rst));
      'h11: r.push_back(8'h03);
      'h14: r.push_back(8'(m_opt * 128 + m_sat * 64 + m_pol * 32 + m_band * 16 +
                           int'(cascade_avail) * 8 + 7));
      'h20: m_band = 0; 'h21: m_pol = 0; 'h22: m_sat = 0; 'h23: m_opt = 0;
      'h24: m_band = 1; 'h25: m_pol = 1; 'h26: m_sat = 1; 'h27: m_opt = 1;
      'h30: m_slp = 1;
      'h31: m_slp = 0;
      'h38: begin
        bits[0] = m_band; bits[1] = m_pol; bits[2] = m_sat; bits[3] = m_opt;
        for (int k = 0; k < 4; k++) begin
          if (d[k]) bits[k] = 1;
          else if (d[k + 4]) bits[k] = 0;
        end
        m_band = bits[0]; m_pol = bits[1]; m_sat = bits[2]; m_opt = bits[3];
      end
      'h50: begin
        if (m_band != 0) begin r.push_back(8'h10); r.push_back(8'h60); end
        else begin r.push_back(8'h09); r.push_back(8'h75); end
      end
      'h51: r.push_back((m_band != 0) ? 8'h04 : 8'h02);
      'h52: r.push_back(8'h02);
      'h53: r.push_back(8'h04);
      default: ok = 0;
    endcase
    if (ok && rep) begin
      exp_q.push_back(8'hE4);
      foreach (r[i]) exp_q.push_back(r[i]);
    end
  endtask

  // Per-clock comparison and reply sink
  always @(negedge clk) begin
    if (!finished) begin
      rdy_cnt++;
      out_ready = (rdy_cnt % 3) != 0;
      check(sw_state == model_sw(), cur_req, "sw_state", sw_state, model_sw());
      if (rst_n && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected reply byte", out_byte, 0);
        end else begin
          check(out_byte == exp_q[0], cur_req, "reply byte", out_byte, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic send_msg(input string req);
    int t;
    cur_req = req;
    foreach (msg[i]) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = msg[i];
      in_last  = (i == msg.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
    @(posedge clk);
    #1 model_apply();
    t = 0;
    while (exp_q.size() != 0 && t < 40) begin
      @(negedge clk);
      t++;
    end
    if (exp_q.size() != 0) begin
      check(1'b0, req, "reply bytes missing", exp_q.size(), 0);
      exp_q.delete();
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic m3(input string req, input logic [7:0] a, b, c);
    msg = {a, b, c};
    send_msg(req);
  endtask

  task automatic m4(input string req, input logic [7:0] a, b, c, d);
    msg = {a, b, c, d};
    send_msg(req);
  endtask

  task automatic do_reset(input logic role, input logic casc, input logic dc);
    @(posedge clk);
    #2 rst_n = 1'b0;
    lnb_role = role; cascade_avail = casc; dc_high = dc;
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired in %s actual=hung expected=done", cur_req);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R13: outputs idle while reset is held
    check(sw_state == 4'h0, "R13", "sw_state in reset", sw_state, 0);
    check(out_valid == 1'b0, "R13", "out_valid in reset", out_valid, 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: status after reset, flag handling
    m3("R6", 8'hE2, 8'h11, 8'h10);
    m3("R6", 8'hE0, 8'h10, 8'h01);
    m3("R6", 8'hE3, 8'h00, 8'h10);
    // R9
    m3("R9", 8'hE2, 8'h10, 8'h11);
    // R4 / R5
    m3("R4", 8'hE0, 8'h11, 8'h27);
    m3("R4", 8'hE2, 8'h11, 8'h25);
    m3("R5", 8'hE2, 8'h11, 8'h14);
    // R10: band-dependent readback
    m3("R10", 8'hE2, 8'h11, 8'h50);
    m3("R10", 8'hE2, 8'h11, 8'h51);
    m3("R4", 8'hE0, 8'h11, 8'h24);
    m3("R10", 8'hE2, 8'h11, 8'h50);
    m3("R10", 8'hE3, 8'h11, 8'h51);
    m3("R10", 8'hE2, 8'h11, 8'h52);
    m3("R10", 8'hE2, 8'h11, 8'h53);
    // R3: foreign addresses ignored in LNB role
    m3("R3", 8'hE2, 8'h14, 8'h23);
    m3("R3", 8'hE2, 8'h12, 8'h10);
    // R1: bad framing ignored
    m3("R1", 8'hE8, 8'h11, 8'h20);
    m3("R1", 8'hF2, 8'h11, 8'h23);
    m3("R1", 8'hD2, 8'h11, 8'h10);
    // R2: no reply on non-request framing, yet command acts
    m3("R2", 8'hE1, 8'h11, 8'h20);
    m3("R2", 8'hE7, 8'h11, 8'h14);
    // R11: port-group writes
    m4("R11", 8'hE2, 8'h11, 8'h38, 8'hF5);
    m4("R11", 8'hE0, 8'h11, 8'h38, 8'h3A);
    m4("R11", 8'hE0, 8'h11, 8'h38, 8'hC0);
    m3("R11", 8'hE2, 8'h11, 8'h14);
    // R12: wrong lengths and unknown commands
    m4("R12", 8'hE2, 8'h11, 8'h24, 8'h55);
    m3("R12", 8'hE2, 8'h11, 8'h38);
    m3("R12", 8'hE2, 8'h11, 8'h99);
    msg = {8'hE2, 8'h11, 8'h38, 8'h0F, 8'h00};
    send_msg("R12");
    msg = {8'hE2, 8'h11};
    send_msg("R12");
    m3("R12", 8'hE2, 8'h11, 8'h14);
    // R7: contention-gated address access
    m3("R7", 8'hE2, 8'h11, 8'h05);
    m3("R7", 8'hE2, 8'h11, 8'h07);
    m4("R7", 8'hE2, 8'h11, 8'h08, 8'h22);
    m3("R6", 8'hE2, 8'h11, 8'h04);
    m3("R6", 8'hE2, 8'h11, 8'h10);
    m3("R7", 8'hE2, 8'h11, 8'h07);
    m4("R7", 8'hE2, 8'h11, 8'h09, 8'h33);
    m3("R7", 8'hE2, 8'h11, 8'h05);
    m4("R7", 8'hE2, 8'h11, 8'h08, 8'h12);
    m3("R7", 8'hE2, 8'h11, 8'h14);
    m3("R7", 8'hE2, 8'h12, 8'h14);
    m3("R6", 8'hE2, 8'h12, 8'h06);
    m4("R7", 8'hE2, 8'h12, 8'h09, 8'h13);
    m3("R7", 8'hE2, 8'h13, 8'h07);
    // R8: sleep
    m3("R8", 8'hE2, 8'h00, 8'h30);
    m3("R8", 8'hE2, 8'h00, 8'h27);
    m3("R8", 8'hE2, 8'h13, 8'h10);
    m3("R8", 8'hE2, 8'h00, 8'h00);
    m3("R8", 8'hE2, 8'h00, 8'h31);
    m3("R8", 8'hE2, 8'h00, 8'h27);
    m3("R8", 8'hE2, 8'h13, 8'h10);
    // R6: decoder reset command restores defaults
    m3("R6", 8'hE2, 8'h04, 8'h04);
    m3("R6", 8'hE2, 8'h00, 8'h04);
    m3("R6", 8'hE2, 8'h00, 8'h00);
    m3("R6", 8'hE2, 8'h11, 8'h10);
    m3("R6", 8'hE2, 8'h13, 8'h10);

    // Multiswitch role
    do_reset(1'b0, 1'b0, 1'b0);
    cur_req = "R13";
    check(sw_state == 4'h0, "R13", "sw_state after reset", sw_state, 0);
    check(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);
    m3("R3", 8'hE2, 8'h14, 8'h14);
    m3("R3", 8'hE2, 8'h11, 8'h26);
    m3("R3", 8'hE2, 8'h14, 8'h26);
    m3("R5", 8'hE2, 8'h14, 8'h14);
    m3("R6", 8'hE2, 8'h10, 8'h10);
    m3("R10", 8'hE2, 8'h14, 8'h50);
    m3("R3", 8'hE2, 8'h14, 8'h07);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule